// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Refresh Scheduling

This block connects a plain host request port to a dynamic memory array whose address pins are shared between row and column. For every host access it breaks the address into an upper (row) half and a lower (column) half. It places them one after the other on a single narrow address bus. The row half is qualified by an active-low row strobe and the column half by an active-low column strobe. Write data is driven onto the array data lines. Read data is captured and handed back with a one-cycle valid pulse.

Dynamic cells lose their charge, so the block also keeps its own refresh schedule. A row counter supplies the row for each refresh, and a refresh cycle opens only that row. A mode input selects between two refresh policies. The distributed policy spreads single-row refreshes evenly over the retention window and slips them in between host accesses. The burst policy, once per window, stalls the host and sweeps every row back to back. Refresh always takes priority over a waiting host request.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_cs_n` are all 1, `dram_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: A request accepted at clock edge e (with `req_valid` and `req_ready` both 1) drives `req_addr[2*HALF_W-1:HALF_W]` on `dram_addr` with `dram_ras_n`=0 and `dram_cas_n`=1 in the cycle after e. In the next cycle it drives `req_addr[HALF_W-1:0]` with both strobes at 0.
- R3: All array controls are active low. `dram_cs_n` is 0 for the whole time `dram_ras_n` is 0 during an access. `dram_cas_n` is 0 only while `dram_ras_n` is 0. While `dram_cas_n` is 0, `dram_we_n` is 1 for a read (`req_write`=0) and 0 for a write (`req_write`=1).
- R4: `dram_dq_oe` is 1 only while `dram_cas_n` and `dram_we_n` are both 0, and during that time `dram_dq_out` equals the accepted write data.
- R5: For a read accepted at edge e, `dram_dq_in` is sampled at edge e+3. `rsp_valid` is 1 with that data on `rsp_rdata` in the cycle after e+3 only. A write produces no `rsp_valid`.
- R6: After every row activation, `dram_ras_n`, `dram_cas_n` and `dram_cs_n` stay at 1 for PRE_CYC cycles plus one idle cycle before `dram_ras_n` can fall again. `req_ready` is 0 throughout that time.
- R7: A refresh cycle holds `dram_ras_n` at 0 for exactly one cycle, with `dram_cas_n` and `dram_we_n` at 1, and the refresh row on `dram_addr`.
- R8: Refresh rows are issued in the order 0, 1, … NUM_ROWS-1 and then wrap back to 0.
- R9: Every row is activated at least once in any span of RETAIN = CLK_KHZ*RETAIN_US/1000 cycles, plus a bounded delay of NUM_ROWS*(3+PRE_CYC)+8 cycles for host traffic and burst ordering.
- R10: With `burst_mode`=0 and the host idle, consecutive refreshes start exactly SLOT = RETAIN/NUM_ROWS cycles apart.
- R11: With `burst_mode`=1, once every NUM_ROWS*SLOT cycles the block issues NUM_ROWS refreshes that start 2+PRE_CYC cycles apart. `req_ready` stays 0 from the first of them until the last one has precharged.
- R12: When a refresh is owed, `req_ready` is 0 and the refresh starts before any host request. A request held in the meantime is served afterwards with its data intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_mode | input | 1 | 1 selects the burst refresh policy, 0 selects distributed |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 2*HALF_W | Full cell address, row half in the upper bits |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted at this edge when high together with req_valid |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | HALF_W | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Read/write line, high = read, low = write |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_dq_out | output | DATA_W | Data toward the array |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data from the array |

## Verification
A behavioural array in the bench latches the row on the falling row strobe and the column on the falling column strobe. The bench then drives writes and reads through it, with address pairs that are row/column mirror images (0x3C and 0xC3) and extreme addresses (0x00, 0xFF). A swapped or truncated half therefore shows up as aliased data. An exact cycle-by-cycle walk of one write and one read pins down the strobe order, the data-drive window and the response latency. A refresh monitor runs in both policies. It tells the two apart by the spacing between refreshes (one slot in distributed mode, 2+PRE_CYC cycles in burst mode). It also checks the row order and its wrap, and how long each row goes without being opened.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_DATA = 3'd3,
    ST_PRE  = 3'd4
  } dmc_state_e;

  // Cycles in one retention window for a given clock.
  function automatic int retain_cycles(input int clk_khz, input int ret_us);
    longint prod;
    prod = longint'(clk_khz) * longint'(ret_us);
    return int'(prod / 1000);
  endfunction

  // Spacing between single-row refreshes in distributed mode.
  function automatic int slot_cycles(input int retain, input int rows);
    return retain / rows;
  endfunction

  // Bits needed to hold refresh debt up to twice a full sweep.
  function automatic int debt_width(input int rows);
    return $clog2(2 * rows + 1);
  endfunction

endpackage

// File: rtl/dmc_refresh_timer.sv
module dmc_refresh_timer #(
  parameter int SLOT_CYC = 31,
  parameter int NUM_ROWS = 16,
  parameter int DEBT_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_mode,
  input  logic              ref_start,
  output logic              slot_tick,
  output logic              frame_tick,
  output logic [DEBT_W-1:0] ref_debt
);

  localparam int SLOT_W   = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam int IDX_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int DEBT_MAX = 2 * NUM_ROWS;

  logic [SLOT_W-1:0] slot_cnt;
  logic [IDX_W-1:0]  slot_idx;
  logic [DEBT_W:0]   debt_sum;
  logic [DEBT_W:0]   debt_add;

  assign slot_tick  = (slot_cnt == SLOT_W'(SLOT_CYC - 1));
  assign frame_tick = slot_tick && (slot_idx == IDX_W'(NUM_ROWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_cnt <= '0;
      slot_idx <= '0;
    end else begin
      slot_cnt <= slot_tick ? '0 : slot_cnt + 1'b1;
      if (slot_tick) begin
        slot_idx <= frame_tick ? '0 : slot_idx + 1'b1;
      end
    end
  end

  // Debt grows by one per slot (distributed) or by a full sweep per
  // window (burst); each started refresh pays one back.
  always_comb begin
    debt_add = '0;
    if (burst_mode) begin
      if (frame_tick) debt_add = (DEBT_W+1)'(NUM_ROWS);
    end else if (slot_tick) begin
      debt_add = (DEBT_W+1)'(1);
    end
    debt_sum = {1'b0, ref_debt} + debt_add;
    if (ref_start) debt_sum = debt_sum - (DEBT_W+1)'(1);
    if (debt_sum > (DEBT_W+1)'(DEBT_MAX)) debt_sum = (DEBT_W+1)'(DEBT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_debt <= '0;
    else        ref_debt <= debt_sum[DEBT_W-1:0];
  end

endmodule

// File: rtl/dmc_row_counter.sv
module dmc_row_counter #(
  parameter int ROW_W    = 4,
  parameter int NUM_ROWS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
    end else if (adv) begin
      row <= (row == LAST_ROW) ? '0 : row + 1'b1;
    end
  end

endmodule

// File: rtl/dmc_access_fsm.sv
module dmc_access_fsm
  import dmc_pkg::*;
#(
  parameter int HALF_W  = 4,
  parameter int DATA_W  = 8,
  parameter int PRE_CYC = 2,
  parameter int DEBT_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [2*HALF_W-1:0] req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ready,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic [DEBT_W-1:0]   ref_debt,
  input  logic [HALF_W-1:0]   ref_row,
  output logic                ref_start,
  output logic [HALF_W-1:0]   dram_addr,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic                dram_cs_n,
  output logic [DATA_W-1:0]   dram_dq_out,
  output logic                dram_dq_oe,
  input  logic [DATA_W-1:0]   dram_dq_in
);

  localparam int PRE_W = $clog2(PRE_CYC + 1);

  dmc_state_e        state;
  logic              is_ref;
  logic              is_wr;
  logic [HALF_W-1:0] row_q;
  logic [HALF_W-1:0] col_q;
  logic [DATA_W-1:0] wdata_q;
  logic [PRE_W-1:0]  pre_cnt;
  logic              ref_owed;
  logic              col_phase;

  assign ref_owed  = (ref_debt != '0);
  assign ref_start = (state == ST_IDLE) && ref_owed;
  assign req_ready = (state == ST_IDLE) && !ref_owed;
  assign col_phase = (state == ST_COL) || (state == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      is_ref    <= 1'b0;
      is_wr     <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      wdata_q   <= '0;
      pre_cnt   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ref_owed) begin
            is_ref <= 1'b1;
            is_wr  <= 1'b0;
            row_q  <= ref_row;
            state  <= ST_ROW;
          end else if (req_valid) begin
            is_ref  <= 1'b0;
            is_wr   <= req_write;
            row_q   <= req_addr[2*HALF_W-1:HALF_W];
            col_q   <= req_addr[HALF_W-1:0];
            wdata_q <= req_wdata;
            state   <= ST_ROW;
          end
        end
        ST_ROW: begin
          pre_cnt <= '0;
          state   <= is_ref ? ST_PRE : ST_COL;
        end
        ST_COL: begin
          state <= ST_DATA;
        end
        ST_DATA: begin
          if (!is_wr) begin
            rsp_rdata <= dram_dq_in;
            rsp_valid <= 1'b1;
          end
          pre_cnt <= '0;
          state   <= ST_PRE;
        end
        ST_PRE: begin
          if (pre_cnt == PRE_W'(PRE_CYC - 1)) state <= ST_IDLE;
          else                                pre_cnt <= pre_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Array pins decoded from the state register only.
  always_comb begin
    dram_ras_n = 1'b1;
    dram_cas_n = 1'b1;
    dram_we_n  = 1'b1;
    dram_cs_n  = 1'b1;
    dram_addr  = row_q;
    case (state)
      ST_ROW: begin
        dram_cs_n  = 1'b0;
        dram_ras_n = 1'b0;
      end
      ST_COL, ST_DATA: begin
        dram_cs_n  = 1'b0;
        dram_ras_n = 1'b0;
        dram_cas_n = 1'b0;
        dram_we_n  = !is_wr;
        dram_addr  = col_q;
      end
      default: ;
    endcase
  end

  assign dram_dq_oe  = col_phase && is_wr;
  assign dram_dq_out = dram_dq_oe ? wdata_q : '0;

endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
  import dmc_pkg::*;
#(
  parameter int HALF_W    = 4,
  parameter int NUM_ROWS  = 16,
  parameter int DATA_W    = 8,
  parameter int CLK_KHZ   = 125000,
  parameter int RETAIN_US = 4000,
  parameter int PRE_CYC   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                burst_mode,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [2*HALF_W-1:0] req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ready,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [HALF_W-1:0]   dram_addr,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic                dram_cs_n,
  output logic [DATA_W-1:0]   dram_dq_out,
  output logic                dram_dq_oe,
  input  logic [DATA_W-1:0]   dram_dq_in
);

  localparam int RETAIN_CYC = retain_cycles(CLK_KHZ, RETAIN_US);
  localparam int SLOT_CYC   = slot_cycles(RETAIN_CYC, NUM_ROWS);
  localparam int DEBT_W     = debt_width(NUM_ROWS);

  // Internal events, named for the bound checker.
  logic              ref_start;
  logic              slot_tick;
  logic              frame_tick;
  logic [DEBT_W-1:0] ref_debt;
  logic [HALF_W-1:0] ref_row;

  dmc_refresh_timer #(
    .SLOT_CYC (SLOT_CYC),
    .NUM_ROWS (NUM_ROWS),
    .DEBT_W   (DEBT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_mode (burst_mode),
    .ref_start  (ref_start),
    .slot_tick  (slot_tick),
    .frame_tick (frame_tick),
    .ref_debt   (ref_debt)
  );

  dmc_row_counter #(
    .ROW_W    (HALF_W),
    .NUM_ROWS (NUM_ROWS)
  ) u_rowcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (ref_start),
    .row   (ref_row)
  );

  dmc_access_fsm #(
    .HALF_W  (HALF_W),
    .DATA_W  (DATA_W),
    .PRE_CYC (PRE_CYC),
    .DEBT_W  (DEBT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .ref_debt    (ref_debt),
    .ref_row     (ref_row),
    .ref_start   (ref_start),
    .dram_addr   (dram_addr),
    .dram_ras_n  (dram_ras_n),
    .dram_cas_n  (dram_cas_n),
    .dram_we_n   (dram_we_n),
    .dram_cs_n   (dram_cs_n),
    .dram_dq_out (dram_dq_out),
    .dram_dq_oe  (dram_dq_oe),
    .dram_dq_in  (dram_dq_in)
  );

endmodule

// File: rtl/dmc_chk.sv
module dmc_chk #(
  parameter int HALF_W = 4,
  parameter int DEBT_W = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [2*HALF_W-1:0] req_addr,
  input logic                rsp_valid,
  input logic [HALF_W-1:0]   dram_addr,
  input logic                dram_ras_n,
  input logic                dram_cas_n,
  input logic                dram_we_n,
  input logic                dram_cs_n,
  input logic                dram_dq_oe,
  input logic                ref_start,
  input logic [DEBT_W-1:0]   ref_debt,
  input logic [HALF_W-1:0]   ref_row
);

  // R2
  row_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!dram_ras_n && dram_cas_n &&
      (dram_addr == $past(req_addr[2*HALF_W-1:HALF_W]))));

  // R3
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> (!dram_ras_n && !dram_cs_n));

  // R4
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> (!dram_cas_n && !dram_we_n));

  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  ref_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_start |=> (!dram_ras_n && dram_cas_n && dram_we_n));

  // R7
  ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_start ##1 1'b1) |=> dram_ras_n);

  // R8
  ref_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_start |=> (dram_addr == $past(ref_row)));

  // R12
  ref_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_debt != '0) |-> !req_ready);

endmodule

bind dram_mux_ctrl dmc_chk #(
  .HALF_W (HALF_W),
  .DEBT_W (DEBT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .dram_addr  (dram_addr),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_cs_n  (dram_cs_n),
  .dram_dq_oe (dram_dq_oe),
  .ref_start  (ref_start),
  .ref_debt   (ref_debt),
  .ref_row    (ref_row)
);

// File: tb/sim_dram_mux_ctrl.sv
module sim_dram_mux_ctrl;

  localparam int HW    = 4;
  localparam int NR    = 16;
  localparam int DW    = 8;
  localparam int PRE   = 2;
  localparam int RET   = (125000 * 4) / 1000;   // 500 cycles
  localparam int SLOT  = RET / NR;              // 31 cycles
  localparam int SLACK = NR * (3 + PRE) + 8;
  localparam int NVEC  = 12;

  // {write, addr, data (write data or expected read data)}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 8'h11}, {1'b1, 8'hFF, 8'hEE}, {1'b1, 8'h3C, 8'hA5},
    {1'b1, 8'hC3, 8'h5A}, {1'b0, 8'h00, 8'h11}, {1'b0, 8'hFF, 8'hEE},
    {1'b0, 8'h3C, 8'hA5}, {1'b0, 8'hC3, 8'h5A}, {1'b1, 8'h3C, 8'h0F},
    {1'b0, 8'h3C, 8'h0F}, {1'b1, 8'h81, 8'h80}, {1'b0, 8'h81, 8'h80}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          burst_mode = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata, dram_dq_out, dram_dq_in;
  logic [HW-1:0] dram_addr;
  logic          dram_ras_n, dram_cas_n, dram_we_n, dram_cs_n, dram_dq_oe;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dram_mux_ctrl #(
    .HALF_W (HW), .NUM_ROWS (NR), .DATA_W (DW),
    .CLK_KHZ (125000), .RETAIN_US (4), .PRE_CYC (PRE)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .burst_mode (burst_mode),
    .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
    .req_wdata (req_wdata), .req_ready (req_ready), .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata), .dram_addr (dram_addr), .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n), .dram_we_n (dram_we_n), .dram_cs_n (dram_cs_n),
    .dram_dq_out (dram_dq_out), .dram_dq_oe (dram_dq_oe), .dram_dq_in (dram_dq_in)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural array: row on falling RAS, column on falling CAS.
  logic [DW-1:0] mem [256];
  logic [HW-1:0] row_lat = '0;
  logic          ras_q = 1'b1, cas_q = 1'b1;

  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  always @(posedge clk) begin
    ras_q <= dram_ras_n;
    cas_q <= dram_cas_n;
    if (!dram_ras_n && ras_q) row_lat <= dram_addr;
    if (!dram_cas_n && cas_q && !dram_we_n) mem[{row_lat, dram_addr}] <= dram_dq_out;
  end

  assign dram_dq_in = mem[{row_lat, dram_addr}];

  // Refresh and activation monitor, sampled at the falling edge.
  int          ncyc = 0;
  logic        prev_ras = 1'b1;
  int          seg_len, seg_start, rise_cyc = 0;
  logic [HW-1:0] seg_addr;
  bit          seg_cas, seg_we_low;
  int          exp_row = 0;
  int          ref_cnt = 0;
  int          last_ref = 0;
  int          last_gap = 0;
  int          run4 = 0, max_run4 = 0;
  bit          wrap_seen = 0;
  int          last_act [NR];

  always @(negedge clk) begin
    ncyc++;
    if (!rst_n) begin
      for (int r = 0; r < NR; r++) last_act[r] = ncyc;
      prev_ras = 1'b1;
      rise_cyc = ncyc;
    end else begin
      if (dram_dq_oe)  // R4
        chk(!dram_cas_n && !dram_we_n, "R4 drive window", {dram_cas_n, dram_we_n}, 0);
      if (!dram_ras_n) begin
        if (prev_ras) begin
          chk(ncyc - rise_cyc >= PRE + 1, "R6 precharge gap", ncyc - rise_cyc, PRE + 1);
          chk(ncyc - last_act[dram_addr] <= RET + SLACK, "R9 retention",
              ncyc - last_act[dram_addr], RET + SLACK);
          last_act[dram_addr] = ncyc;
          seg_len = 0; seg_start = ncyc; seg_addr = dram_addr;
          seg_cas = 0; seg_we_low = 0;
        end
        seg_len++;
        if (!dram_cas_n) seg_cas = 1;
        if (!dram_we_n)  seg_we_low = 1;
      end else if (!prev_ras) begin
        rise_cyc = ncyc;
        if (!seg_cas) begin
          chk(seg_len == 1 && !seg_we_low, "R7 refresh shape", seg_len, 1);
          chk(seg_addr == HW'(exp_row), "R8 refresh row", seg_addr, exp_row);
          if (exp_row == NR - 1) wrap_seen = 1;
          exp_row = (exp_row + 1) % NR;
          last_gap = seg_start - last_ref;
          last_ref = seg_start;
          ref_cnt++;
          if (last_gap == 2 + PRE) begin
            run4++;
            if (run4 > max_run4) max_run4 = run4;
          end else run4 = 0;
        end
      end
      prev_ras = dram_ras_n;
    end
  end

  task automatic host_op(input logic wr, input logic [7:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = '0;
    if (!wr) begin
      while (!rsp_valid) @(negedge clk);
      rd = rsp_rdata;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int base;
    // R1 during and right after reset
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_cs_n, "R1 strobes in reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_cs_n}, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_cs_n && !dram_dq_oe,
        "R1 strobes idle", {dram_ras_n, dram_cas_n, dram_we_n, dram_cs_n}, 4'hF);
    chk(req_ready && !rsp_valid, "R1 ready", {req_ready, rsp_valid}, 2'b10);

    // Exact walk of one write, then one read of the same cell.
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'hA5; req_wdata = 8'h3C;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!dram_ras_n && dram_cas_n, "R2 row strobe", {dram_ras_n, dram_cas_n}, 2'b01);
    chk(dram_addr == 4'hA, "R2 row half", dram_addr, 4'hA);
    chk(!dram_cs_n, "R3 select in row", dram_cs_n, 0);
    @(negedge clk);
    chk(!dram_ras_n && !dram_cas_n, "R2 column strobe", {dram_ras_n, dram_cas_n}, 0);
    chk(dram_addr == 4'h5, "R2 column half", dram_addr, 4'h5);
    chk(!dram_we_n, "R3 write level", dram_we_n, 0);
    chk(dram_dq_oe && dram_dq_out == 8'h3C, "R4 write data", dram_dq_out, 8'h3C);
    @(negedge clk);
    chk(!dram_cas_n && !dram_we_n && !dram_cs_n, "R3 data phase",
        {dram_cas_n, dram_we_n, dram_cs_n}, 0);
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_cs_n, "R6 precharge strobes",
        {dram_ras_n, dram_cas_n, dram_cs_n}, 3'b111);
    chk(!req_ready, "R6 ready low 1", req_ready, 0);
    chk(!rsp_valid, "R5 no response for write", rsp_valid, 0);
    @(negedge clk);
    chk(!req_ready, "R6 ready low 2", req_ready, 0);
    @(negedge clk);
    chk(req_ready, "R6 ready back", req_ready, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'hA5;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!dram_ras_n && dram_addr == 4'hA, "R2 read row", dram_addr, 4'hA);
    @(negedge clk);
    chk(dram_we_n && !dram_dq_oe, "R3 read level", {dram_we_n, dram_dq_oe}, 2'b10);
    @(negedge clk);
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == 8'h3C, "R5 read data", rsp_rdata, 8'h3C);
    @(negedge clk);
    chk(!rsp_valid, "R5 pulse width", rsp_valid, 0);

    // Vector table: writes and read-backs with refresh interleaved.
    for (int v = 0; v < NVEC; v++) begin
      host_op(VEC[v][16], VEC[v][15:8], VEC[v][7:0], rd);
      if (!VEC[v][16])
        chk(rd == VEC[v][7:0], "R2 R5 vector read", rd, VEC[v][7:0]);
    end

    // R10: idle distributed spacing.
    for (int k = 0; k < 3; k++) begin
      base = ref_cnt;
      while (ref_cnt == base) @(negedge clk);
    end
    chk(last_gap == SLOT, "R10 distributed spacing", last_gap, SLOT);

    // R11 / R12: burst sweep holds off a waiting request.
    burst_mode = 1'b1;
    do begin
      base = ref_cnt;
      while (ref_cnt == base) @(negedge clk);
    end while (last_gap <= 2 + PRE);
    base = ref_cnt;
    chk(!req_ready, "R11 host stalled in burst", req_ready, 0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h00;
    while (!req_ready) @(negedge clk);
    chk(ref_cnt - base == NR - 1, "R12 refresh before host", ref_cnt - base, NR - 1);
    chk(max_run4 >= NR - 1, "R11 back-to-back", max_run4, NR - 1);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_rdata == 8'h11, "R12 held request served", rsp_rdata, 8'h11);

    // Another full window in burst mode, then the retention sweep.
    repeat (RET + 40) @(negedge clk);
    for (int r = 0; r < NR; r++)
      chk(ncyc - last_act[r] <= RET + SLACK, "R9 final retention", ncyc - last_act[r], RET + SLACK);
    chk(wrap_seen && exp_row < NR, "R8 wrap", wrap_seen, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule